// File: doc/BRIEF.md
# OSD Serial Command Receiver

This block sits between a host microcontroller and the display engine of an on-screen-display overlay. The host drives a three-wire serial port: an active-low select, a shift clock and a data line. The receiver brings all three into the system clock domain and assembles 8-bit words. It sorts each word into a command header or a data word, and keeps the current command so that it can steer later data. Three kinds of output come from it: a bank of configuration fields for the display engine, the current write address for the character memory, and a one-cycle write strobe that carries a character code and an attribute flag.

Two sequences behave differently from the rest. A character-write header places the receiver in a locked write mode, and in that mode every later word is a character code, whatever its top bit. The lock stays until the select line is raised. Raising the select line always returns the receiver to the address-setup command. A header for display control (command 4) with its low bit set clears every register. It then holds them cleared, and ignores all input, until the select line rises.

Top module: `osd_cmd_rx`

## Requirements
- R1: A data bit is taken on each rising edge of `ser_clk` while `ser_cs_n` is low, most significant bit first, and eight bits make one word. If `ser_cs_n` goes high before a word is complete, the bits already received are thrown away.
- R2: A word with bit 7 = 1 is a header, and its bits 6:4 give the command number 0 to 7, which appears on `cmd_o`. A word with bit 7 = 0 is a data word.
- R3: Every data word goes to the command named by the most recent header, until another header arrives.
- R4: A header of command 1 (binary 1001xxxa) enters write mode (`wmode_o` = 1). In write mode each word, including one whose bit 7 is 1, produces exactly one cycle of `wr_en_o`. That cycle carries the word on `wr_code_o` and bit 0 of the header on `wr_attr_o`.
- R5: While `ser_cs_n` is high, `cmd_o` returns to 0 and write mode ends.
- R6: A header of command 0 loads bits 3:0 into the row address. A data word that follows command 0 loads bits 4:0 into the column address.
- R7: Each character write uses the current row and column, which appear on `wr_row_o` and `wr_col_o`. The write then advances the column. After column 23 the column goes to 0 and the row advances, and after row 11 the row goes to 0.
- R8: A header of command k, for k from 2 to 7, stores bits 3:0 in `cfg_head_o[(k-2)*4 +: 4]`. A data word that follows it stores bits 6:0 in `cfg_body_o[(k-2)*7 +: 7]`.
- R9: A command 4 header with bit 0 = 1 clears every register, including the address, the command and the configuration bank. All later words are ignored until `ser_cs_n` goes high.
- R10: `rst_n` low clears every register and output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial shift clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data |
| cmd_o | output | 3 | Current command number |
| wmode_o | output | 1 | Locked character-write mode |
| addr_row_o | output | 4 | Current write row |
| addr_col_o | output | 5 | Current write column |
| wr_en_o | output | 1 | Character memory write strobe |
| wr_row_o | output | 4 | Row of the write |
| wr_col_o | output | 5 | Column of the write |
| wr_code_o | output | 8 | Character code of the write |
| wr_attr_o | output | 1 | Attribute flag of the write |
| cfg_head_o | output | 24 | Header fields of commands 2 to 7 |
| cfg_body_o | output | 42 | Data fields of commands 2 to 7 |

## Verification
The case to watch is a character write and an address wrap on the same clock edge. The strobe must carry the old address while the address registers take the wrapped value. The bench places the address at row 11, column 23 and at row 3, column 23, and then streams codes. A scoreboard compares each strobe with the queued row, column, code and attribute, and direct checks read the address ports after the wrap. A second collision, a high-bit character code arriving in write mode, is judged by the absence of any header effect and by the presence of the expected strobe.

// File: rtl/osd_cmd_rx.sv
module osd_cmd_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int ROWS        = 12,
  parameter int COLS        = 24,
  parameter int CODE_W      = 8,
  parameter int NUM_CFG     = 6,
  parameter int HEAD_W      = 4,
  parameter int BODY_W      = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_cs_n,
  input  logic                        ser_clk,
  input  logic                        ser_dat,
  output logic [2:0]                  cmd_o,
  output logic                        wmode_o,
  output logic [$clog2(ROWS)-1:0]     addr_row_o,
  output logic [$clog2(COLS)-1:0]     addr_col_o,
  output logic                        wr_en_o,
  output logic [$clog2(ROWS)-1:0]     wr_row_o,
  output logic [$clog2(COLS)-1:0]     wr_col_o,
  output logic [CODE_W-1:0]           wr_code_o,
  output logic                        wr_attr_o,
  output logic [NUM_CFG*HEAD_W-1:0]   cfg_head_o,
  output logic [NUM_CFG*BODY_W-1:0]   cfg_body_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int CNT_W = $clog2(CODE_W);
  localparam int FIRST_CFG = 2;

  logic [SYNC_STAGES-1:0] cs_sy, ck_sy, dt_sy;
  logic                   ck_d;
  logic [CODE_W-2:0]      sh_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   attr_q, hold_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy <= '1;
      ck_sy <= '1;
      dt_sy <= '0;
      ck_d  <= 1'b1;
    end else begin
      cs_sy <= {cs_sy[SYNC_STAGES-2:0], ser_cs_n};
      ck_sy <= {ck_sy[SYNC_STAGES-2:0], ser_clk};
      dt_sy <= {dt_sy[SYNC_STAGES-2:0], ser_dat};
      ck_d  <= ck_sy[SYNC_STAGES-1];
    end

  wire cs_hi = cs_sy[SYNC_STAGES-1];
  wire rise  = ck_sy[SYNC_STAGES-1] & ~ck_d;
  wire [CODE_W-1:0] byte_v = {sh_q, dt_sy[SYNC_STAGES-1]};
  wire byte_done = rise & ~cs_hi & (cnt_q == CNT_W'(CODE_W-1));
  wire live      = byte_done & ~hold_q;
  wire [2:0] id_in = byte_v[CODE_W-2 -: 3];
  wire first_we  = live & ~wmode_o &  byte_v[CODE_W-1];
  wire data_we   = live & ~wmode_o & ~byte_v[CODE_W-1];
  wire char_we   = live &  wmode_o;
  wire sys_clr   = first_we & (id_in == 3'd4) & byte_v[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (cs_hi) begin
      cnt_q <= '0;
    end else if (rise) begin
      sh_q  <= byte_v[CODE_W-2:0];
      cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
    end

  wire col_last = (addr_col_o == COL_W'(COLS-1));
  wire row_last = (addr_row_o == ROW_W'(ROWS-1));
  wire [COL_W-1:0] nxt_col = col_last ? '0 : addr_col_o + 1'b1;
  wire [ROW_W-1:0] nxt_row = !col_last ? addr_row_o : (row_last ? '0 : addr_row_o + 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_o      <= '0;
      wmode_o    <= 1'b0;
      hold_q     <= 1'b0;
      attr_q     <= 1'b0;
      addr_row_o <= '0;
      addr_col_o <= '0;
      wr_en_o    <= 1'b0;
      wr_row_o   <= '0;
      wr_col_o   <= '0;
      wr_code_o  <= '0;
      wr_attr_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (cs_hi) begin
        cmd_o   <= '0;
        wmode_o <= 1'b0;
        hold_q  <= 1'b0;
      end
      if (char_we) begin
        wr_en_o    <= 1'b1;
        wr_row_o   <= addr_row_o;
        wr_col_o   <= addr_col_o;
        wr_code_o  <= byte_v;
        wr_attr_o  <= attr_q;
        addr_row_o <= nxt_row;
        addr_col_o <= nxt_col;
      end
      if (first_we) begin
        cmd_o <= id_in;
        if (id_in == 3'd0) addr_row_o <= byte_v[ROW_W-1:0];
        if (id_in == 3'd1) begin
          wmode_o <= 1'b1;
          attr_q  <= byte_v[0];
        end
      end
      if (data_we && cmd_o == 3'd0) addr_col_o <= byte_v[COL_W-1:0];
      if (sys_clr) begin
        cmd_o      <= '0;
        hold_q     <= 1'b1;
        attr_q     <= 1'b0;
        addr_row_o <= '0;
        addr_col_o <= '0;
        wr_row_o   <= '0;
        wr_col_o   <= '0;
        wr_code_o  <= '0;
        wr_attr_o  <= 1'b0;
      end
    end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic [HEAD_W-1:0] head_q;
    logic [BODY_W-1:0] body_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        head_q <= '0;
        body_q <= '0;
      end else if (sys_clr) begin
        head_q <= '0;
        body_q <= '0;
      end else begin
        if (first_we && id_in == 3'(g + FIRST_CFG)) head_q <= byte_v[HEAD_W-1:0];
        if (data_we && cmd_o == 3'(g + FIRST_CFG))  body_q <= byte_v[BODY_W-1:0];
      end
    assign cfg_head_o[g*HEAD_W +: HEAD_W] = head_q;
    assign cfg_body_o[g*BODY_W +: BODY_W] = body_q;
  end

  AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (cmd_o == 3'd0 && !wmode_o)); // R5
  AST_WR_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> wmode_o); // R4
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o); // R4
  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_col_o == COL_W'(COLS-1)) |-> addr_col_o == '0); // R7
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_col_o == COL_W'(COLS-1) && wr_row_o == ROW_W'(ROWS-1)) |-> addr_row_o == '0); // R7
  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (cfg_head_o == '0 && cfg_body_o == '0 && addr_row_o == '0 && addr_col_o == '0 && !wr_en_o)); // R9
endmodule

// File: tb/test_osd_cmd_rx.sv
module test_osd_cmd_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_cs_n = 1'b1, ser_clk = 1'b1, ser_dat = 1'b0;
  logic [2:0]  cmd_o;
  logic        wmode_o, wr_en_o, wr_attr_o;
  logic [3:0]  addr_row_o, wr_row_o;
  logic [4:0]  addr_col_o, wr_col_o;
  logic [7:0]  wr_code_o;
  logic [23:0] cfg_head_o;
  logic [41:0] cfg_body_o;

  always #10 clk = ~clk;

  osd_cmd_rx i_osd_cmd_rx (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [17:0] exp_q[$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] b, int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      ser_dat = b[i];
      ser_clk = 1'b0;
      wait_clk(3);
      ser_clk = 1'b1;
      wait_clk(3);
    end
    wait_clk(4);
  endtask

  task automatic send(logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic put(logic [7:0] code, logic [3:0] row, logic [4:0] col, logic attr);
    exp_q.push_back({row, col, code, attr});
    send(code);
  endtask

  task automatic sel(bit low);
    ser_cs_n = ~low;
    wait_clk(5);
  endtask

  always @(negedge clk)
    if (rst_n && wr_en_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4 unexpected write actual=%0h expected=none",
                 {wr_row_o, wr_col_o, wr_code_o, wr_attr_o});
      end else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        if ({wr_row_o, wr_col_o, wr_code_o, wr_attr_o} !== e) begin
          n_fail++;
          $display("FAIL R4/R7 write actual=%0h expected=%0h",
                   {wr_row_o, wr_col_o, wr_code_o, wr_attr_o}, e);
        end
      end
    end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R10 reset outputs", {cmd_o, wmode_o, addr_row_o, addr_col_o, wr_en_o, cfg_head_o, cfg_body_o}, '0);

    sel(1);
    send(8'h85); send(8'h0A);
    chk("R6 row", addr_row_o, 5);
    chk("R6 col", addr_col_o, 10);
    chk("R2 cmd0", cmd_o, 0);
    send(8'h91);
    chk("R4 wmode", wmode_o, 1);
    chk("R2 cmd1", cmd_o, 1);
    put(8'h41, 5, 10, 1);
    put(8'hC3, 5, 11, 1);
    chk("R4 high code kept mode", {cmd_o, wmode_o}, {3'd1, 1'b1});
    chk("R7 col advance", addr_col_o, 12);
    sel(0);
    chk("R5 cs high", {cmd_o, wmode_o}, {3'd0, 1'b0});

    sel(1);
    send(8'h8B); send(8'h17); send(8'h90);
    put(8'h7E, 11, 23, 0);
    chk("R7 full wrap", {addr_row_o, addr_col_o}, 9'd0);
    put(8'h55, 0, 0, 0);
    sel(0);
    sel(1);
    send(8'h83); send(8'h17); send(8'h91);
    put(8'h20, 3, 23, 1);
    chk("R7 row advance", {addr_row_o, addr_col_o}, {4'd4, 5'd0});
    sel(0);

    sel(1);
    send(8'hA5); send(8'h3C);
    chk("R8 head2", cfg_head_o[3:0], 5);
    chk("R8 body2", cfg_body_o[6:0], 7'h3C);
    send(8'h12);
    chk("R3 second data", cfg_body_o[6:0], 7'h12);
    send(8'hF9); send(8'h7F);
    chk("R8 head7", cfg_head_o[23:20], 9);
    chk("R8 body7", cfg_body_o[41:35], 7'h7F);
    send(8'hC2); send(8'h2A);
    chk("R8 head4", cfg_head_o[11:8], 2);
    chk("R8 body4", cfg_body_o[20:14], 7'h2A);
    chk("R2 cmd4", cmd_o, 4);
    sel(0);

    sel(1);
    send_bits(8'hF0, 4);
    sel(0);
    sel(1);
    send(8'hB3);
    chk("R1 partial dropped", cfg_head_o[7:4], 3);
    send(8'h85); send(8'h07);
    sel(0);

    sel(1);
    send(8'hC1);
    chk("R9 clear cfg", {cfg_head_o, cfg_body_o}, '0);
    chk("R9 clear addr", {addr_row_o, addr_col_o}, '0);
    send(8'hA7);
    chk("R9 ignored", cfg_head_o[3:0], 0);
    send(8'h91); send(8'h33);
    chk("R9 no mode", wmode_o, 0);
    sel(0);
    sel(1);
    send(8'hA7);
    chk("R9 released", cfg_head_o[3:0], 7);
    sel(0);

    sel(1);
    send(8'hD6); send(8'h11);
    rst_n = 1'b0;
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R10 mid reset", {cmd_o, cfg_head_o, cfg_body_o}, '0);
    sel(0);

    wait_clk(5);
    chk("R4 all writes seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule